// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one data word at a time into an asynchronous serial frame: a low start bit, 7 to 9 data bits, an optional even or odd parity bit, and a stop period of half, one, one and a half or two bit periods. Before each frame it can hold the line high for 0 to 3 extra bit periods. Bit timing comes from an external divider. `sub_tick` pulses `OVS` times per bit period, and `bit_tick` marks the bit grid, coinciding with every `OVS`-th `sub_tick`. Every element of a frame is measured in sub-ticks, so a half stop bit lasts `OVS/2` of them.

A producer hands words over through a valid/ready port into a one-entry holding register. A frame that is waiting starts on the next `bit_tick` when the line is idle. If it arrives while a frame is running, it starts directly after that frame's stop period ends. The frame settings are taken from the configuration inputs when a word moves into the shifter. Output inversion and tristate act at once, after the transmitter logic.

Top module: `uart_fx_tx`

## Requirements
- R1: After reset, `tx` is high (with `line_invert` low), `tx_oe` is 1, `busy` is 0, `in_ready` is 1 and `tx_done` is 0.
- R2: `in_ready` is 1 exactly when the holding register is empty. A word is taken on a clock edge with `in_valid` and `in_ready` both high. A held word starts its frame on the next `bit_tick` edge if the line is idle, or on the edge that ends the running frame's stop period.
- R3: A frame starts with a low start bit lasting `OVS` sub-ticks. Each data bit and the parity bit also last `OVS` sub-ticks. The line is high when idle.
- R4: `cfg_len` selects the data length: 0 gives 7 bits, 1 gives 8 bits, 2 or 3 gives 9 bits, taken from `in_data` bits below that length.
- R5: With `cfg_msb_first` at 0 the least significant bit goes out first. With it at 1 the most significant of the selected bits goes out first.
- R6: `cfg_parity` 1 adds an even parity bit, equal to the XOR of the data bits. `cfg_parity` 2 adds an odd parity bit, the inverse of that XOR. Codes 0 and 3 add no parity bit. The parity bit does not count toward the data length.
- R7: `cfg_stop` sets the high stop period after the last data or parity bit: 0 gives `OVS/2` sub-ticks, 1 gives `OVS`, 2 gives `3*OVS/2`, and 3 gives `2*OVS`.
- R8: `cfg_gap` = g holds the line high for g*`OVS` sub-ticks before the start bit of every frame, including frames sent back to back.
- R9: `tx` equals the internal line level XOR `line_invert`, in the same cycle.
- R10: `tx_oe` is 0 while `line_hiz` is 1 and returns to 1 as soon as it is released. Frame timing continues unchanged meanwhile.
- R11: `busy` is 1 from the edge that starts a frame until the edge that ends its stop period, and stays 1 across back-to-back frames. `tx_done` is a one-cycle pulse after a stop period ends while no word is held.
- R12: Configuration changes made while a frame is in progress do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| sub_tick | input | 1 | One-cycle pulse, OVS per bit period |
| cfg_len | input | 2 | Data length code |
| cfg_parity | input | 2 | Parity code |
| cfg_stop | input | 2 | Stop length code |
| cfg_gap | input | 2 | Idle gap in bit periods before each frame |
| cfg_msb_first | input | 1 | Send MSB first |
| line_invert | input | 1 | Invert serial output |
| line_hiz | input | 1 | Tristate serial output |
| in_valid | input | 1 | Word offered |
| in_data | input | 9 | Word to send |
| in_ready | output | 1 | Holding register empty |
| tx | output | 1 | Serial line |
| tx_oe | output | 1 | Output enable for the line |
| busy | output | 1 | Frame in progress |
| tx_done | output | 1 | Transmit-complete pulse |

## Verification
Results arrive at different times. `in_ready` drops on the edge that takes a word. `busy` and the start bit appear on the edge that starts the frame, which is one `bit_tick` later from idle or the stop-ending edge when frames run back to back. Each later line transition falls on the edge of the sub-tick that completes the element before it, and `tx_done` goes high on the edge that ends the stop period. `tx` and `tx_oe` follow `line_invert` and `line_hiz` with no register delay. A behavioural model keeps the expected frame as a queue of (level, sub-tick count) segments. It advances on the same edges as the design, and every output is compared 5 ns after each rising edge, once all updates from that edge have settled.

// File: rtl/uart_fx_pkg.sv
package uart_fx_pkg;

    localparam int TX_DW = 9;

    typedef enum logic [1:0] {LEN_7 = 2'd0, LEN_8 = 2'd1, LEN_9 = 2'd2, LEN_9X = 2'd3} len_e;
    typedef enum logic [1:0] {PAR_NONE = 2'd0, PAR_EVEN = 2'd1, PAR_ODD = 2'd2, PAR_NONEX = 2'd3} par_e;
    typedef enum logic [1:0] {STP_HALF = 2'd0, STP_ONE = 2'd1, STP_ONEHALF = 2'd2, STP_TWO = 2'd3} stp_e;

    typedef struct packed {
        len_e       len;
        par_e       par;
        stp_e       stp;
        logic [1:0] gap;
        logic       msb_first;
    } frame_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_GAP, ST_START, ST_DATA, ST_PAR, ST_STOP
    } tx_state_e;

endpackage

// File: rtl/uart_fx_hold.sv
module uart_fx_hold #(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          take,
    output logic          in_ready,
    output logic          full,
    output logic [DW-1:0] data
);
    typedef struct packed {
        logic          full;
        logic [DW-1:0] data;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (take) hold_d.full = 1'b0;
        if (in_valid && !hold_q.full) begin
            hold_d.full = 1'b1;
            hold_d.data = in_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign in_ready = !hold_q.full;
    assign full     = hold_q.full;
    assign data     = hold_q.data;

    // R2: a held word is kept unchanged until the sequencer takes it
    p_hold_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q.full && !take) |=> (hold_q.full && $stable(hold_q.data)));

endmodule

// File: rtl/uart_fx_seq.sv
module uart_fx_seq
    import uart_fx_pkg::*;
#(
    parameter int OVS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             sub_tick,
    input  frame_cfg_t       cfg,
    input  logic             pend,
    input  logic [TX_DW-1:0] pend_data,
    output logic             take,
    output logic             line,
    output logic             busy,
    output logic             done
);
    localparam int CW = $clog2(3 * OVS + 1);
    localparam int IW = $clog2(TX_DW + 1);

    typedef struct packed {
        tx_state_e        st;
        logic [CW-1:0]    cnt;
        logic [IW-1:0]    idx;
        logic [IW-1:0]    nbits;
        logic [TX_DW-1:0] shf;
        logic             pbit;
        logic             has_par;
        stp_e             stp;
        logic [1:0]       gap;
        logic             done;
    } seq_t;

    seq_t q, d;

    logic [TX_DW-1:0] msk, rev;
    logic [IW-1:0]    nb;
    logic [CW-1:0]    dur;
    logic             el_end, start_ok;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        take     = 1'b0;
        msk      = '0;
        rev      = '0;

        case (cfg.len)
            LEN_7:   nb = IW'(7);
            LEN_8:   nb = IW'(8);
            default: nb = IW'(9);
        endcase
        for (int i = 0; i < TX_DW; i++)
            if (i < int'(nb)) msk[i] = pend_data[i];
        for (int i = 0; i < TX_DW; i++)
            if (i < int'(nb)) rev[i] = msk[int'(nb) - 1 - i];

        case (q.st)
            ST_GAP: dur = CW'(OVS) * CW'(q.gap);
            ST_STOP: begin
                case (q.stp)
                    STP_HALF:    dur = CW'(OVS / 2);
                    STP_ONE:     dur = CW'(OVS);
                    STP_ONEHALF: dur = CW'(OVS + OVS / 2);
                    default:     dur = CW'(2 * OVS);
                endcase
            end
            default: dur = CW'(OVS);
        endcase

        el_end   = sub_tick && (q.cnt == dur - CW'(1));
        start_ok = pend && ((q.st == ST_IDLE && bit_tick) || (q.st == ST_STOP && el_end));

        if (sub_tick && q.st != ST_IDLE) d.cnt = q.cnt + CW'(1);

        case (q.st)
            ST_GAP: if (el_end) begin
                d.st  = ST_START;
                d.cnt = '0;
            end
            ST_START: if (el_end) begin
                d.st  = ST_DATA;
                d.cnt = '0;
                d.idx = '0;
            end
            ST_DATA: if (el_end) begin
                d.cnt = '0;
                d.shf = q.shf >> 1;
                if (q.idx == q.nbits - IW'(1)) d.st = q.has_par ? ST_PAR : ST_STOP;
                else                           d.idx = q.idx + IW'(1);
            end
            ST_PAR: if (el_end) begin
                d.st  = ST_STOP;
                d.cnt = '0;
            end
            ST_STOP: if (el_end) begin
                d.st   = ST_IDLE;
                d.cnt  = '0;
                d.done = !pend;
            end
            default: ;
        endcase

        if (start_ok) begin
            take      = 1'b1;
            d.cnt     = '0;
            d.idx     = '0;
            d.nbits   = nb;
            d.shf     = cfg.msb_first ? rev : msk;
            d.pbit    = (^msk) ^ (cfg.par == PAR_ODD);
            d.has_par = (cfg.par == PAR_EVEN) || (cfg.par == PAR_ODD);
            d.stp     = cfg.stp;
            d.gap     = cfg.gap;
            d.st      = (cfg.gap != 2'd0) ? ST_GAP : ST_START;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, stp: STP_ONE, default: '0};
        else        q <= d;
    end

    always_comb begin
        case (q.st)
            ST_START: line = 1'b0;
            ST_DATA:  line = q.shf[0];
            ST_PAR:   line = q.pbit;
            default:  line = 1'b1;
        endcase
    end

    assign busy = (q.st != ST_IDLE);
    assign done = q.done;

    // R2: an idle line only leaves idle on a bit_tick edge
    p_idle_waits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && !bit_tick) |=> (q.st == ST_IDLE));

    // R3: element timing advances only on sub-ticks
    p_sub_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE && !sub_tick) |=> ($stable(q.st) && $stable(q.cnt)));

    // R7: no element outlasts the longest duration (3 bit periods)
    p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < CW'(3 * OVS));

    // R11: completion is a single-cycle pulse seen only with the line idle
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.st == ST_IDLE && $past(q.st) == ST_STOP));

endmodule

// File: rtl/uart_fx_pin.sv
module uart_fx_pin (
    input  logic line,
    input  logic invert,
    input  logic hiz,
    output logic tx,
    output logic tx_oe
);
    assign tx    = line ^ invert;
    assign tx_oe = !hiz;
endmodule

// File: rtl/uart_fx_tx.sv
module uart_fx_tx
    import uart_fx_pkg::*;
#(
    parameter int OVS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic       sub_tick,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_parity,
    input  logic [1:0] cfg_stop,
    input  logic [1:0] cfg_gap,
    input  logic       cfg_msb_first,
    input  logic       line_invert,
    input  logic       line_hiz,
    input  logic       in_valid,
    input  logic [8:0] in_data,
    output logic       in_ready,
    output logic       tx,
    output logic       tx_oe,
    output logic       busy,
    output logic       tx_done
);
    frame_cfg_t       cfg;
    logic             take, pend, line;
    logic [TX_DW-1:0] pend_data;

    assign cfg = '{len: len_e'(cfg_len), par: par_e'(cfg_parity), stp: stp_e'(cfg_stop),
                   gap: cfg_gap, msb_first: cfg_msb_first};

    uart_fx_hold #(.DW(TX_DW)) u_hold (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .take(take), .in_ready(in_ready), .full(pend), .data(pend_data)
    );

    uart_fx_seq #(.OVS(OVS)) u_seq (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .sub_tick(sub_tick),
        .cfg(cfg), .pend(pend), .pend_data(pend_data), .take(take),
        .line(line), .busy(busy), .done(tx_done)
    );

    uart_fx_pin u_pin (
        .line(line), .invert(line_invert), .hiz(line_hiz), .tx(tx), .tx_oe(tx_oe)
    );

endmodule

// File: tb/uart_fx_tx_tb.sv
module uart_fx_tx_tb;
    localparam int OVS = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bit_tick = 1'b0, sub_tick = 1'b0;
    logic [1:0] cfg_len = 2'd1, cfg_parity = 2'd0, cfg_stop = 2'd1, cfg_gap = 2'd0;
    logic cfg_msb_first = 1'b0, line_invert = 1'b0, line_hiz = 1'b0;
    logic in_valid = 1'b0;
    logic [8:0] in_data = '0;
    logic in_ready, tx, tx_oe, busy, tx_done;

    int n_chk = 0, n_fail = 0;
    bit r12_phase = 0;

    always #10 clk = ~clk;

    uart_fx_tx #(.OVS(OVS)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .sub_tick(sub_tick),
        .cfg_len(cfg_len), .cfg_parity(cfg_parity), .cfg_stop(cfg_stop), .cfg_gap(cfg_gap),
        .cfg_msb_first(cfg_msb_first), .line_invert(line_invert), .line_hiz(line_hiz),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .tx(tx),
        .tx_oe(tx_oe), .busy(busy), .tx_done(tx_done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // tick divider: sub_tick every other cycle, bit_tick on every OVS-th sub_tick
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            sub_tick = (ph % 2 == 0);
            bit_tick = (ph == 0);
            ph = (ph + 1) % (2 * OVS);
        end
    end

    // behavioural model: expected frame as (level, sub-tick count) segments
    int    q_lvl[$];
    int    q_len[$];
    string q_tag[$];
    bit    m_hold_v = 0;
    logic [8:0] m_hold_d = '0;
    bit    m_done = 0;

    task automatic push(input int lvl, input int len, input string tag);
        q_lvl.push_back(lvl); q_len.push_back(len); q_tag.push_back(tag);
    endtask

    task automatic build(input logic [8:0] d);
        int n, p, s;
        n = (cfg_len == 2'd0) ? 7 : (cfg_len == 2'd1) ? 8 : 9;
        p = 0;
        if (cfg_gap != 0) push(1, int'(cfg_gap) * OVS, "R8");
        push(0, OVS, "R3");
        for (int i = 0; i < n; i++) begin
            int b = cfg_msb_first ? int'(d[n - 1 - i]) : int'(d[i]);
            p ^= b;
            push(b, OVS, "R4 R5");
        end
        if (cfg_parity == 2'd1) push(p, OVS, "R6");
        if (cfg_parity == 2'd2) push(p ^ 1, OVS, "R6");
        case (cfg_stop)
            2'd0:    s = OVS / 2;
            2'd1:    s = OVS;
            2'd2:    s = OVS + OVS / 2;
            default: s = 2 * OVS;
        endcase
        push(1, s, "R7");
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            q_lvl.delete(); q_len.delete(); q_tag.delete();
            m_hold_v = 0; m_done = 0;
        end else begin
            bit was_idle, hv, ended, load;
            was_idle = (q_lvl.size() == 0);
            hv = m_hold_v;
            ended = 0;
            if (!was_idle && sub_tick) begin
                q_len[0] = q_len[0] - 1;
                if (q_len[0] == 0) begin
                    void'(q_lvl.pop_front()); void'(q_len.pop_front()); void'(q_tag.pop_front());
                    if (q_lvl.size() == 0) ended = 1;
                end
            end
            load = hv && (ended || (was_idle && bit_tick));
            m_done = ended && !hv;
            if (load) begin
                build(m_hold_d);
                m_hold_v = 0;
            end
            if (in_valid && !hv) begin
                m_hold_v = 1;
                m_hold_d = in_data;
            end
        end
    end

    // compare every cycle, 5 ns after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rst_n) begin
                string tg;
                int lvl;
                lvl = (q_lvl.size() != 0) ? q_lvl[0] : 1;
                tg  = (q_lvl.size() != 0) ? q_tag[0] : "R3";
                if (line_invert) tg = {tg, " R9"};
                if (r12_phase)   tg = {tg, " R12"};
                chk(tg, "tx", int'(tx), lvl ^ int'(line_invert));
                chk("R10", "tx_oe", int'(tx_oe), int'(!line_hiz));
                chk("R11", "busy", int'(busy), int'(q_lvl.size() != 0));
                chk("R11", "tx_done", int'(tx_done), int'(m_done));
                chk("R2", "in_ready", int'(in_ready), int'(!m_hold_v));
            end
        end
    end

    task automatic send(input logic [8:0] d, input logic [1:0] ln, input logic [1:0] par,
                        input logic [1:0] stp, input logic [1:0] gap, input logic msb);
        forever begin
            @(negedge clk);
            if (in_ready) begin
                cfg_len = ln; cfg_parity = par; cfg_stop = stp; cfg_gap = gap;
                cfg_msb_first = msb;
                in_valid = 1'b1; in_data = d;
                @(negedge clk);
                in_valid = 1'b0;
                break;
            end
        end
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy || !in_ready);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1", "tx", int'(tx), 1);
        chk("R1", "tx_oe", int'(tx_oe), 1);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "in_ready", int'(in_ready), 1);
        chk("R1", "tx_done", int'(tx_done), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        send(9'h0A5, 2'd1, 2'd0, 2'd1, 2'd0, 1'b0); wait_idle();   // 8N1
        send(9'h053, 2'd0, 2'd1, 2'd1, 2'd0, 1'b0); wait_idle();   // 7E1
        send(9'h1A7, 2'd2, 2'd2, 2'd3, 2'd0, 1'b0); wait_idle();   // 9O2
        send(9'h0C3, 2'd1, 2'd0, 2'd0, 2'd0, 1'b0); wait_idle();   // half stop
        send(9'h0B1, 2'd1, 2'd1, 2'd2, 2'd0, 1'b1); wait_idle();   // MSB first, 1.5 stop
        send(9'h14E, 2'd3, 2'd3, 2'd1, 2'd1, 1'b1); wait_idle();   // gap 1
        send(9'h0FF, 2'd1, 2'd2, 2'd1, 2'd3, 1'b0); wait_idle();   // gap 3

        // back to back with half stop and gap 2
        send(9'h011, 2'd1, 2'd1, 2'd0, 2'd2, 1'b0);
        send(9'h122, 2'd2, 2'd0, 2'd0, 2'd2, 1'b0);
        send(9'h033, 2'd0, 2'd2, 2'd2, 2'd0, 1'b1);
        wait_idle();

        // R9 inversion, R10 tristate during a frame
        line_invert = 1'b1;
        send(9'h06C, 2'd1, 2'd1, 2'd1, 2'd0, 1'b0);
        repeat (40) @(negedge clk);
        line_hiz = 1'b1;
        repeat (50) @(negedge clk);
        line_hiz = 1'b0;
        wait_idle();
        line_invert = 1'b0;

        // R12: configuration altered mid-frame
        send(9'h0E4, 2'd1, 2'd1, 2'd3, 2'd0, 1'b0);
        repeat (30) @(negedge clk);
        r12_phase = 1;
        cfg_len = 2'd0; cfg_parity = 2'd2; cfg_stop = 2'd0; cfg_gap = 2'd3; cfg_msb_first = 1'b1;
        wait_idle();
        r12_phase = 0;

        repeat (10) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R11 watchdog expired: actual 0 expected 1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule